// File: doc/BRIEF.md
# Successive-Approximation Converter Controller

This block is the digital half of a 10-bit successive-approximation analog-to-digital converter serving twelve multiplexed inputs. Software selects a channel and sets a start bit; the controller then drives a trial code to an external resistor-string DAC. It reads back one comparator bit per step and resolves the result from the most significant bit down. When the least significant bit is known, it writes the finished code into that channel's own result register.

Results are held left-justified in 16-bit words, so a reader can take the full word or just the upper byte. An 8-bit power-fail threshold is compared against that upper byte after every finished conversion, and a flag reports the outcome. Any rewrite of the mode or channel register while a conversion runs abandons it, and no result is stored.

Top module: `sar_adc_ctrl`

## Requirements
- R1: After reset, every result word reads 0x0000, the threshold reads 0x00, and busy, eoc, pfail and dac_code are all zero.
- R2: A write to address 0 (mode) with bit 0 set, while idle and with a selected channel below 12, raises busy on the next cycle, and in that cycle dac_code equals 0x200 (MSB trial). While idle, dac_code is zero.
- R3: Each step keeps the trial bit when cmp_in is 1 (input at or above the tap) and clears it otherwise, so the stored code equals the largest code whose tap does not exceed the input.
- R4: busy stays high for exactly 11 cycles (10 bit steps plus one transfer), and eoc is then high for exactly one cycle, the first cycle after busy falls.
- R5: A finished conversion writes only the result register of the channel held in the select register (address 1, bits 3:0); all other channels keep their contents.
- R6: A result word holds the 10-bit code in bits 15:6 with bits 5:0 zero, and the byte view rd_hibyte holds code bits 9:2.
- R7: Reading channel index 12 to 15 returns zero on both rd_word and rd_hibyte.
- R8: Address 2 holds the 8-bit threshold, readable on thr_rdata; writes to it take effect on the next cycle.
- R9: At each transfer pfail is updated: with mode bit 1 clear it is set when the new upper byte is below the threshold; with mode bit 1 set it is set when the upper byte is at or above the threshold. It holds between transfers.
- R10: Any write to address 0 or 1 while busy aborts the conversion: busy is low on the next cycle, no eoc follows, and no result register changes.
- R11: A start request while the select register holds 12 or more is ignored: busy stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address: 0 mode, 1 select, 2 threshold |
| cfg_wdata | input | 8 | Register write data |
| cmp_in | input | 1 | Comparator bit: 1 when input is at or above the tap |
| rd_chan | input | 4 | Channel index for result reads |
| dac_code | output | 10 | Trial code to the resistor-string DAC |
| busy | output | 1 | Conversion in progress |
| eoc | output | 1 | One-cycle end-of-conversion pulse |
| pfail | output | 1 | Power-fail compare result of the last transfer |
| rd_word | output | 16 | Selected result, left-justified |
| rd_hibyte | output | 8 | Upper byte of the selected result |
| thr_rdata | output | 8 | Threshold register contents |

## Verification
Conversions run on random channels with random input levels, which exercises the binary search across all bit positions, and on the extremes 0, 1023, 511 and 512, which separate a wrong first decision or a wrong comparison sense from an off-by-one at the low end. Random thresholds in both compare modes, plus cases where the upper byte equals the threshold exactly, tell a strict compare from an inclusive one. Aborts by each of the two register writes, and starts with an out-of-range channel, show that nothing is stored and no pulse appears.

// File: rtl/sar_adc_pkg.sv
package sar_adc_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_STEP = 2'd1,
      ST_XFER = 2'd2
   } sar_state_e;

   localparam logic [1:0] ADDR_MODE = 2'd0;
   localparam logic [1:0] ADDR_SEL  = 2'd1;
   localparam logic [1:0] ADDR_THR  = 2'd2;

   localparam int MODE_START_BIT = 0;
   localparam int MODE_PF_GE_BIT = 1;
endpackage

// File: rtl/sar_step_engine.sv
module sar_step_engine
   import sar_adc_pkg::*;
#(
   parameter int RES_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_req,
   input  logic             abort_req,
   input  logic             cmp_in,
   output logic             busy,
   output logic             xfer_en,
   output logic [RES_W-1:0] sar_q,
   output logic [RES_W-1:0] dac_code
);
   localparam int IDX_W = (RES_W > 1) ? $clog2(RES_W) : 1;

   sar_state_e       st_q;
   logic [IDX_W-1:0] idx_q;
   logic [RES_W-1:0] trial_bit;

   assign trial_bit = RES_W'(1) << idx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ST_IDLE;
         idx_q <= '0;
         sar_q <= '0;
      end else if (abort_req) begin
         st_q  <= ST_IDLE;
         sar_q <= '0;
      end else begin
         unique case (st_q)
            ST_IDLE: begin
               if (start_req) begin
                  st_q  <= ST_STEP;
                  idx_q <= IDX_W'(RES_W - 1);
                  sar_q <= '0;
               end
            end
            ST_STEP: begin
               sar_q[idx_q] <= cmp_in;
               if (idx_q == '0) st_q <= ST_XFER;
               else             idx_q <= idx_q - 1'b1;
            end
            ST_XFER: st_q <= ST_IDLE;
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign busy     = (st_q != ST_IDLE);
   assign xfer_en  = (st_q == ST_XFER) && !abort_req;
   assign dac_code = (st_q == ST_STEP) ? (sar_q | trial_bit) : '0;
endmodule

// File: rtl/sar_result_bank.sv
module sar_result_bank #(
   parameter int N_CH   = 12,
   parameter int CH_W   = 4,
   parameter int RES_W  = 10,
   parameter int WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [CH_W-1:0]   wr_ch,
   input  logic [RES_W-1:0]  wr_res,
   input  logic [CH_W-1:0]   rd_ch,
   output logic [WORD_W-1:0] rd_word
);
   localparam int PAD_W = WORD_W - RES_W;

   logic [RES_W-1:0] res_q [N_CH];

   for (genvar c = 0; c < N_CH; c++) begin : g_ch
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                              res_q[c] <= '0;
         else if (wr_en && (wr_ch == CH_W'(c)))   res_q[c] <= wr_res;
      end
   end

   always_comb begin
      rd_word = '0;
      for (int c = 0; c < N_CH; c++) begin
         if (rd_ch == CH_W'(c)) begin
            if (PAD_W > 0) rd_word = {res_q[c], {PAD_W{1'b0}}};
            else           rd_word = WORD_W'(res_q[c]);
         end
      end
   end
endmodule

// File: rtl/sar_pf_flag.sv
module sar_pf_flag #(
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              upd,
   input  logic              mode_ge,
   input  logic [BYTE_W-1:0] hi_byte,
   input  logic [BYTE_W-1:0] thr,
   output logic              pfail
);
   logic below;
   assign below = (hi_byte < thr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   pfail <= 1'b0;
      else if (upd) pfail <= mode_ge ? !below : below;
   end
endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl
   import sar_adc_pkg::*;
#(
   parameter int RES_W  = 10,
   parameter int N_CH   = 12,
   parameter int CH_W   = 4,
   parameter int WORD_W = 16,
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr_en,
   input  logic [1:0]        cfg_addr,
   input  logic [7:0]        cfg_wdata,
   input  logic              cmp_in,
   input  logic [CH_W-1:0]   rd_chan,
   output logic [RES_W-1:0]  dac_code,
   output logic              busy,
   output logic              eoc,
   output logic              pfail,
   output logic [WORD_W-1:0] rd_word,
   output logic [BYTE_W-1:0] rd_hibyte,
   output logic [BYTE_W-1:0] thr_rdata
);
   if (RES_W > WORD_W || BYTE_W > RES_W || BYTE_W > 8 || CH_W > 8 || N_CH > (1 << CH_W)) begin : g_bad_cfg
      $error("sar_adc_ctrl: inconsistent width parameters");
   end

   logic [CH_W-1:0]   sel_q;
   logic [BYTE_W-1:0] thr_q;
   logic              pf_ge_q;
   logic              wr_mode, wr_sel, wr_thr;
   logic              start_req, abort_req, xfer_en;
   logic [RES_W-1:0]  sar_q;

   assign wr_mode   = cfg_wr_en && (cfg_addr == ADDR_MODE);
   assign wr_sel    = cfg_wr_en && (cfg_addr == ADDR_SEL);
   assign wr_thr    = cfg_wr_en && (cfg_addr == ADDR_THR);
   assign abort_req = busy && (wr_mode || wr_sel);
   assign start_req = !busy && wr_mode && cfg_wdata[MODE_START_BIT] && (sel_q < CH_W'(N_CH));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q   <= '0;
         thr_q   <= '0;
         pf_ge_q <= 1'b0;
         eoc     <= 1'b0;
      end else begin
         if (wr_sel)  sel_q   <= cfg_wdata[CH_W-1:0];
         if (wr_thr)  thr_q   <= cfg_wdata[BYTE_W-1:0];
         if (wr_mode) pf_ge_q <= cfg_wdata[MODE_PF_GE_BIT];
         eoc <= xfer_en;
      end
   end

   sar_step_engine #(.RES_W(RES_W)) u_engine (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_req (start_req),
      .abort_req (abort_req),
      .cmp_in    (cmp_in),
      .busy      (busy),
      .xfer_en   (xfer_en),
      .sar_q     (sar_q),
      .dac_code  (dac_code)
   );

   sar_result_bank #(
      .N_CH(N_CH), .CH_W(CH_W), .RES_W(RES_W), .WORD_W(WORD_W)
   ) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (xfer_en),
      .wr_ch   (sel_q),
      .wr_res  (sar_q),
      .rd_ch   (rd_chan),
      .rd_word (rd_word)
   );

   sar_pf_flag #(.BYTE_W(BYTE_W)) u_pf (
      .clk     (clk),
      .rst_n   (rst_n),
      .upd     (xfer_en),
      .mode_ge (pf_ge_q),
      .hi_byte (sar_q[RES_W-1 -: BYTE_W]),
      .thr     (thr_q),
      .pfail   (pfail)
   );

   assign rd_hibyte = rd_word[WORD_W-1 -: BYTE_W];
   assign thr_rdata = thr_q;
endmodule

// File: rtl/sar_adc_ctrl_chk.sv
module sar_adc_ctrl_chk #(
   parameter int RES_W  = 10,
   parameter int N_CH   = 12,
   parameter int CH_W   = 4,
   parameter int WORD_W = 16,
   parameter int BYTE_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_wr_en,
   input logic [1:0]        cfg_addr,
   input logic [7:0]        cfg_wdata,
   input logic [CH_W-1:0]   rd_chan,
   input logic [RES_W-1:0]  dac_code,
   input logic              busy,
   input logic              eoc,
   input logic              pfail,
   input logic [WORD_W-1:0] rd_word,
   input logic [BYTE_W-1:0] rd_hibyte,
   input logic [BYTE_W-1:0] thr_q,
   input logic              pf_ge_q,
   input logic [CH_W-1:0]   sel_q,
   input logic [RES_W-1:0]  sar_q
);
   localparam int PAD_W = WORD_W - RES_W;
   logic [7:0] run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) run_q <= '0;
      else        run_q <= busy ? run_q + 8'd1 : 8'd0;
   end

   assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr_en && cfg_addr == 2'd0 && cfg_wdata[0] && !busy && sel_q < CH_W'(N_CH))
      |=> (busy && dac_code == (RES_W'(1) << (RES_W - 1))));

   assert_idle_dac_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> dac_code == '0);

   assert_eoc_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
      eoc |-> (!busy && $past(busy) && run_q == 8'(RES_W + 1)));

   assert_eoc_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
      eoc |=> !eoc);

   assert_word_fmt_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_word[PAD_W-1:0] == '0) && (rd_hibyte == rd_word[WORD_W-1 -: BYTE_W]));

   assert_rd_void_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_chan >= CH_W'(N_CH)) |-> (rd_word == '0));

   assert_pf_R9: assert property (@(posedge clk) disable iff (!rst_n)
      eoc |-> (pfail == ($past(pf_ge_q) ? ($past(sar_q[RES_W-1 -: BYTE_W]) >= $past(thr_q))
                                        : ($past(sar_q[RES_W-1 -: BYTE_W]) <  $past(thr_q)))));

   assert_abort_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cfg_wr_en && (cfg_addr == 2'd0 || cfg_addr == 2'd1)) |=> (!busy && !eoc));

   assert_badch_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && sel_q >= CH_W'(N_CH) && !(cfg_wr_en && cfg_addr == 2'd1)) |=> !busy);
endmodule

bind sar_adc_ctrl sar_adc_ctrl_chk #(
   .RES_W(RES_W), .N_CH(N_CH), .CH_W(CH_W), .WORD_W(WORD_W), .BYTE_W(BYTE_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
   .cfg_wdata(cfg_wdata), .rd_chan(rd_chan), .dac_code(dac_code), .busy(busy),
   .eoc(eoc), .pfail(pfail), .rd_word(rd_word), .rd_hibyte(rd_hibyte),
   .thr_q(thr_q), .pf_ge_q(pf_ge_q), .sel_q(sel_q), .sar_q(sar_q)
);

// File: tb/tb_sar_adc_ctrl.sv
`timescale 1ns/1ps
module tb_sar_adc_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr_en = 1'b0;
   logic [1:0]  cfg_addr = '0;
   logic [7:0]  cfg_wdata = '0;
   logic        cmp_in;
   logic [3:0]  rd_chan = '0;
   logic [9:0]  dac_code;
   logic        busy, eoc, pfail;
   logic [15:0] rd_word;
   logic [7:0]  rd_hibyte, thr_rdata;
   logic [9:0]  vin = '0;

   int checks = 0;
   int errors = 0;
   bit done = 0;
   logic [9:0] model [12];

   always #2.5 clk = ~clk;
   assign cmp_in = (vin >= dac_code);

   sar_adc_ctrl dut (
      .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cmp_in(cmp_in), .rd_chan(rd_chan),
      .dac_code(dac_code), .busy(busy), .eoc(eoc), .pfail(pfail),
      .rd_word(rd_word), .rd_hibyte(rd_hibyte), .thr_rdata(thr_rdata)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic pf_exp(input logic [9:0] v, input logic [7:0] th, input logic ge);
      return ge ? (v[9:2] >= th) : (v[9:2] < th);
   endfunction

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      cfg_wr_en = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_wr_en = 1'b0;
   endtask

   task automatic check_all(input string tag);
      for (int c = 0; c < 16; c++) begin
         rd_chan = 4'(c); #1;
         if (c < 12) begin
            chk(tag, rd_word, {model[c], 6'b0});
            chk(tag, rd_hibyte, model[c][9:2]);
         end else begin
            chk({tag, " R7"}, rd_word, 0);
            chk({tag, " R7"}, rd_hibyte, 0);
         end
      end
   endtask

   task automatic run_conv(input int ch, input logic [9:0] v, input logic ge, input logic [7:0] th);
      int n;
      wr(2'd2, th);
      chk("R8 threshold", thr_rdata, th);
      wr(2'd1, 8'(ch));
      vin = v;
      wr(2'd0, {6'b0, ge, 1'b1});
      chk("R2 busy", busy, 1);
      chk("R2 msb trial", dac_code, 10'h200);
      n = 0;
      while (busy && n < 40) begin n++; @(negedge clk); end
      chk("R4 busy length", n, 11);
      chk("R4 eoc", eoc, 1);
      model[ch] = v;
      chk("R9 pfail", pfail, pf_exp(v, th, ge));
      rd_chan = 4'(ch); #1;
      chk("R3 result", rd_word, {v, 6'b0});
      chk("R6 hibyte", rd_hibyte, v[9:2]);
      @(negedge clk);
      chk("R4 eoc width", eoc, 0);
      chk("R2 idle dac", dac_code, 0);
   endtask

   task automatic run_abort(input int ch, input logic [1:0] a);
      wr(2'd1, 8'(ch));
      vin = 10'h155;
      wr(2'd0, 8'h01);
      repeat (4) @(negedge clk);
      wr(a, (a == 2'd1) ? 8'(ch) : 8'h00);
      chk("R10 abort busy", busy, 0);
      for (int k = 0; k < 15; k++) begin
         chk("R10 no eoc", eoc, 0);
         @(negedge clk);
      end
      check_all("R10 unchanged");
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int seed;
      seed = $urandom(32'd2024);
      for (int c = 0; c < 12; c++) model[c] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 busy", busy, 0);
      chk("R1 eoc", eoc, 0);
      chk("R1 pfail", pfail, 0);
      chk("R1 dac", dac_code, 0);
      chk("R1 thr", thr_rdata, 0);
      check_all("R1 results");

      // directed extremes
      run_conv(0, 10'd0, 1'b0, 8'h00);
      run_conv(11, 10'd1023, 1'b0, 8'hFF);
      run_conv(5, 10'd511, 1'b1, 8'h7F);
      run_conv(6, 10'd512, 1'b0, 8'h80);
      run_conv(7, 10'd512, 1'b0, 8'h81);
      run_conv(8, 10'd3, 1'b1, 8'h01);
      check_all("R5 directed");

      // R11 out-of-range channel
      wr(2'd1, 8'd13);
      wr(2'd0, 8'h01);
      chk("R11 no start", busy, 0);
      repeat (12) @(negedge clk);
      chk("R11 no eoc", eoc, 0);
      check_all("R11 unchanged");

      // R10 aborts through both registers
      run_abort(2, 2'd0);
      run_abort(9, 2'd1);

      // random conversions
      for (int i = 0; i < 60; i++) begin
         int ch;
         logic [9:0] v;
         logic [7:0] th;
         ch = int'($urandom_range(0, 11));
         v  = 10'($urandom);
         th = (i % 5 == 0) ? v[9:2] : 8'($urandom);
         run_conv(ch, v, 1'($urandom), th);
         if (i % 10 == 9) check_all("R5 random");
      end

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule